// File: doc/BRIEF.md
# Block-Transfer Memory Slot Sequencer

This block decides, cycle by cycle, what a 2D block-transfer engine does with its memory slot: nothing, a read from source A, a read from source C, or a write to destination D. For each access it also names the address pointer that supplies the address. Address arithmetic, shifting, logic functions and data storage sit in neighbouring blocks. Those blocks follow the slot tags this sequencer emits.

There are two operating styles. In the word-stream style, each word costs three slots. Reads run one word ahead of writes. One idle slot fills the pipeline at the start, and one idle slot drains it before the final write. In the line-draw style, each pixel costs four slots: idle, read C, idle, write D. Pixels never overlap. A slot advances only while the bus grant is high. A start pulse launches a run, and a one-cycle done pulse ends it.

Top module: `blit_slot_seq`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `kind_o`/`ptr_o` are 0. Kind encoding: 0 idle, 1 read A, 2 read C, 3 write D. Pointer encoding: 0 none, 1 A pointer, 2 C pointer, 3 D pointer.
- R2: In word-stream mode (`line_mode_i`=0) with all enables set, a run of N words emits these slots: read A0, read C0, idle. Then, for n=1..N-1, the groups read An, read Cn, write D(n-1). Then idle, then write D(N-1).
- R3: In word-stream mode a run takes exactly 3N+2 granted slots. Each D write for word n follows the reads of word n+1. Reads use pointers A and C, and writes use pointer D.
- R4: In line mode (`line_mode_i`=1) each of the N pixels takes exactly four slots in the order idle, read C, idle, write D, so a run takes 4N granted slots.
- R5: In line mode no slot is ever a read of A, whatever `en_a_i` is. `en_d_i`=0 does not suppress the writes.
- R6: In line mode with `en_c_i`=0 every slot is idle. The run still lasts 4N slots and ends with a done pulse.
- R7: In line mode the first pixel's write uses the D pointer, and every later pixel's write uses the C pointer.
- R8: On a cycle where `grant_i` is 0 while busy, the presented slot (kind and pointer) stays the same on the next cycle and is not skipped.
- R9: `busy_o` rises the cycle after an accepted start. It falls the cycle after the last slot is granted. In that same cycle `done_o` is high, and only for one cycle.
- R10: A start pulse while `busy_o` is 1 is ignored, and the running schedule continues unchanged.
- R11: `count_i`=0 runs as a count of one word or pixel.
- R12: In word-stream mode a cleared `en_a_i`, `en_c_i` or `en_d_i` turns that channel's slots into idle slots with pointer none. The three-slot cadence and the run length are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when not busy |
| line_mode_i | input | 1 | 1 selects line-draw mode, 0 selects word-stream mode |
| en_a_i | input | 1 | Source A enable |
| en_c_i | input | 1 | Source C enable |
| en_d_i | input | 1 | Destination D enable |
| count_i | input | CNT_W | Number of words or pixels, 0 treated as 1 |
| grant_i | input | 1 | Bus grant; the presented slot is consumed when high |
| kind_o | output | 2 | Slot kind: 0 idle, 1 read A, 2 read C, 3 write D |
| ptr_o | output | 2 | Pointer select: 0 none, 1 A, 2 C, 3 D |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse after the last slot |

## Verification
A wrong phase or word index shows up in the first slot it affects. The kind or pointer tag differs from the arithmetic schedule at that slot. So the bench compares every slot of every run against a model. It sweeps both modes, counts 0 to 5, all enable combinations and three grant patterns. A wrong end condition moves the falling edge of busy and the done pulse. These are checked at the exact cycle 3N+2 or 4N granted slots after start. A start pulse injected mid-run is checked too: it must leave the rest of the schedule intact.

// File: rtl/blit_slot_pkg.sv
package blit_slot_pkg;

  typedef enum logic [1:0] {
    K_IDLE = 2'd0,
    K_RD_A = 2'd1,
    K_RD_C = 2'd2,
    K_WR_D = 2'd3
  } slot_kind_t;

  typedef enum logic [1:0] {
    P_NONE = 2'd0,
    P_A    = 2'd1,
    P_C    = 2'd2,
    P_D    = 2'd3
  } ptr_sel_t;

  localparam int unsigned NORM_GROUP = 3;
  localparam int unsigned LINE_GROUP = 4;

endpackage

// File: rtl/blit_slot_ctrl.sv
module blit_slot_ctrl #(
  parameter int unsigned CNT_W = 4,
  localparam int unsigned IDX_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             grant_i,
  input  logic             line_i,
  input  logic             en_a_i,
  input  logic             en_c_i,
  input  logic             en_d_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             line_o,
  output logic             en_a_o,
  output logic             en_c_o,
  output logic             en_d_o,
  output logic [1:0]       phase_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] num_o
);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             line_q, line_d;
  logic             ea_q, ea_d, ec_q, ec_d, ed_q, ed_d;
  logic [1:0]       phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] num_q, num_d;

  logic       launch, step, at_end, phase_wrap;
  logic [1:0] phase_max;

  always_comb begin
    launch = start_i & ~busy_q;
    step   = busy_q & grant_i;

    // Word-stream: last group (index == num) holds only idle + final write.
    if (line_q) begin
      phase_max = 2'd3;
    end else if (idx_q == num_q) begin
      phase_max = 2'd1;
    end else begin
      phase_max = 2'd2;
    end
    phase_wrap = (phase_q == phase_max);

    if (line_q) begin
      at_end = step & phase_wrap & (idx_q == num_q - IDX_W'(1));
    end else begin
      at_end = step & phase_wrap & (idx_q == num_q);
    end

    busy_d  = busy_q;
    done_d  = at_end;
    line_d  = line_q;
    ea_d    = ea_q;
    ec_d    = ec_q;
    ed_d    = ed_q;
    phase_d = phase_q;
    idx_d   = idx_q;
    num_d   = num_q;

    if (launch) begin
      busy_d  = 1'b1;
      line_d  = line_i;
      ea_d    = en_a_i;
      ec_d    = en_c_i;
      ed_d    = en_d_i;
      phase_d = 2'd0;
      idx_d   = '0;
      num_d   = (count_i == '0) ? IDX_W'(1) : IDX_W'(count_i);
    end else if (at_end) begin
      busy_d  = 1'b0;
      phase_d = 2'd0;
      idx_d   = '0;
    end else if (step) begin
      if (phase_wrap) begin
        phase_d = 2'd0;
        idx_d   = idx_q + IDX_W'(1);
      end else begin
        phase_d = phase_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      line_q  <= 1'b0;
      ea_q    <= 1'b0;
      ec_q    <= 1'b0;
      ed_q    <= 1'b0;
      phase_q <= 2'd0;
      idx_q   <= '0;
      num_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      line_q  <= line_d;
      ea_q    <= ea_d;
      ec_q    <= ec_d;
      ed_q    <= ed_d;
      phase_q <= phase_d;
      idx_q   <= idx_d;
      num_q   <= num_d;
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign line_o  = line_q;
  assign en_a_o  = ea_q;
  assign en_c_o  = ec_q;
  assign en_d_o  = ed_q;
  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign num_o   = num_q;

endmodule

// File: rtl/blit_slot_norm.sv
module blit_slot_norm
  import blit_slot_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [1:0]       phase_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W-1:0] num_i,
  input  logic             en_a_i,
  input  logic             en_c_i,
  input  logic             en_d_i,
  output slot_kind_t       kind_o,
  output ptr_sel_t         ptr_o
);

  logic drain_grp, first_grp;

  always_comb begin
    drain_grp = (idx_i == num_i);
    first_grp = (idx_i == '0);
    kind_o    = K_IDLE;
    ptr_o     = P_NONE;
    if (drain_grp) begin
      // drain: idle, then the write of the last word
      if (phase_i == 2'd1 && en_d_i) begin
        kind_o = K_WR_D;
        ptr_o  = P_D;
      end
    end else begin
      unique case (phase_i)
        2'd0: if (en_a_i) begin
          kind_o = K_RD_A;
          ptr_o  = P_A;
        end
        2'd1: if (en_c_i) begin
          kind_o = K_RD_C;
          ptr_o  = P_C;
        end
        2'd2: if (!first_grp && en_d_i) begin
          kind_o = K_WR_D;
          ptr_o  = P_D;
        end
        default: begin
          kind_o = K_IDLE;
          ptr_o  = P_NONE;
        end
      endcase
    end
  end

endmodule

// File: rtl/blit_slot_line.sv
module blit_slot_line
  import blit_slot_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic [1:0]       phase_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             en_c_i,
  output slot_kind_t       kind_o,
  output ptr_sel_t         ptr_o
);

  always_comb begin
    kind_o = K_IDLE;
    ptr_o  = P_NONE;
    if (en_c_i) begin
      if (phase_i == 2'd1) begin
        kind_o = K_RD_C;
        ptr_o  = P_C;
      end else if (phase_i == 2'd3) begin
        kind_o = K_WR_D;
        ptr_o  = (idx_i == '0) ? P_D : P_C;
      end
    end
  end

endmodule

// File: rtl/blit_slot_seq.sv
module blit_slot_seq
  import blit_slot_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  localparam int unsigned IDX_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             line_mode_i,
  input  logic             en_a_i,
  input  logic             en_c_i,
  input  logic             en_d_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             grant_i,
  output logic [1:0]       kind_o,
  output logic [1:0]       ptr_o,
  output logic             busy_o,
  output logic             done_o
);

  logic             busy, done, line_q, ea, ec, ed;
  logic [1:0]       phase;
  logic [IDX_W-1:0] idx, num;
  slot_kind_t       n_kind, l_kind;
  ptr_sel_t         n_ptr, l_ptr;

  blit_slot_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .grant_i (grant_i),
    .line_i  (line_mode_i),
    .en_a_i  (en_a_i),
    .en_c_i  (en_c_i),
    .en_d_i  (en_d_i),
    .count_i (count_i),
    .busy_o  (busy),
    .done_o  (done),
    .line_o  (line_q),
    .en_a_o  (ea),
    .en_c_o  (ec),
    .en_d_o  (ed),
    .phase_o (phase),
    .idx_o   (idx),
    .num_o   (num)
  );

  blit_slot_norm #(.IDX_W(IDX_W)) u_norm (
    .phase_i (phase),
    .idx_i   (idx),
    .num_i   (num),
    .en_a_i  (ea),
    .en_c_i  (ec),
    .en_d_i  (ed),
    .kind_o  (n_kind),
    .ptr_o   (n_ptr)
  );

  blit_slot_line #(.IDX_W(IDX_W)) u_line (
    .phase_i (phase),
    .idx_i   (idx),
    .en_c_i  (ec),
    .kind_o  (l_kind),
    .ptr_o   (l_ptr)
  );

  always_comb begin
    if (!busy) begin
      kind_o = K_IDLE;
      ptr_o  = P_NONE;
    end else if (line_q) begin
      kind_o = l_kind;
      ptr_o  = l_ptr;
    end else begin
      kind_o = n_kind;
      ptr_o  = n_ptr;
    end
  end

  assign busy_o = busy;
  assign done_o = done;

endmodule

// File: rtl/blit_slot_chk.sv
module blit_slot_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       grant,
  input logic       line_mode,
  input logic [1:0] kind,
  input logic [1:0] ptr
);

  p_idle_when_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (kind == 2'd0 && ptr == 2'd0));

  p_creads_use_c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == 2'd2) |-> (ptr == 2'd2));

  p_no_a_in_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && line_mode) |-> (kind != 2'd1));

  p_line_wr_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && line_mode && kind == 2'd3) |-> (ptr == 2'd3 || ptr == 2'd2));

  p_hold_no_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !grant) |=> (busy && $stable(kind) && $stable(ptr)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind blit_slot_seq blit_slot_chk u_chk (
  .clk       (clk_i),
  .rst_n     (rst_ni),
  .busy      (busy_o),
  .done      (done_o),
  .grant     (grant_i),
  .line_mode (line_q),
  .kind      (kind_o),
  .ptr       (ptr_o)
);

// File: tb/blit_slot_seq_tb.sv
module blit_slot_seq_tb;

  localparam int CNT_W = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             start_i, line_mode_i, en_a_i, en_c_i, en_d_i, grant_i;
  logic [CNT_W-1:0] count_i;
  logic [1:0]       kind_o, ptr_o;
  logic             busy_o, done_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #10 clk_i = ~clk_i;

  blit_slot_seq #(.CNT_W(CNT_W)) u_dut (
    .clk_i, .rst_ni, .start_i, .line_mode_i, .en_a_i, .en_c_i, .en_d_i,
    .count_i, .grant_i, .kind_o, .ptr_o, .busy_o, .done_o
  );

  always @(posedge clk_i) cyc <= cyc + 1;

  initial begin
    wait (cyc > 150000);
    bad++;
    total++;
    $display("FAIL watchdog: run hung, cycles=%0d expected < 150000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input int actual, input int expected, input string what);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, actual, expected);
    end
  endtask

  // expected slot k of a run, from the requirement text
  function automatic void exp_slot(input bit line, input int n, input int k,
                                   input bit ea, input bit ec, input bit ed,
                                   output int ek, output int ep);
    int g, p;
    ek = 0; ep = 0;
    if (line) begin
      g = k / 4; p = k % 4;
      if (ec && p == 1) begin ek = 2; ep = 2; end
      if (ec && p == 3) begin ek = 3; ep = (g == 0) ? 3 : 2; end
    end else begin
      g = k / 3; p = k % 3;
      if (g < n) begin
        if (p == 0 && ea) begin ek = 1; ep = 1; end
        if (p == 1 && ec) begin ek = 2; ep = 2; end
        if (p == 2 && g > 0 && ed) begin ek = 3; ep = 3; end
      end else if (p == 1 && ed) begin
        ek = 3; ep = 3;
      end
    end
  endfunction

  task automatic run(input bit line, input int cnt, input bit ea, input bit ec,
                     input bit ed, input int gpat, input bit inject);
    int n, tlen, s, step, ek, ep;
    string tag;
    bit g;
    n    = (cnt == 0) ? 1 : cnt;
    tlen = line ? 4 * n : 3 * n + 2;
    if (line) tag = ec ? "R4 R5 R7" : "R6";
    else      tag = (ea && ec && ed) ? "R2 R3" : "R12";
    if (cnt == 0) tag = {tag, " R11"};
    if (gpat != 0) tag = {tag, " R8"};
    if (inject) tag = {tag, " R10"};
    @(negedge clk_i);
    line_mode_i = line; en_a_i = ea; en_c_i = ec; en_d_i = ed;
    count_i = CNT_W'(cnt); start_i = 1'b1; grant_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    line_mode_i = ~line; en_a_i = ~ea; en_c_i = ~ec; en_d_i = ~ed; count_i = 4'd7;
    chk("R9", int'(busy_o), 1, "busy after start");
    s = 0; step = 0;
    while (s < tlen && step < 2000) begin
      exp_slot(line, n, s, ea, ec, ed, ek, ep);
      chk(tag, int'(busy_o), 1, $sformatf("busy slot %0d", s));
      chk(tag, int'(kind_o), ek, $sformatf("kind slot %0d", s));
      chk(tag, int'(ptr_o), ep, $sformatf("ptr slot %0d", s));
      case (gpat)
        1: g = (step % 3) != 2;
        2: g = (step % 2) == 1;
        default: g = 1'b1;
      endcase
      grant_i = g;
      start_i = (inject && s == 2);
      if (g) s++;
      step++;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    grant_i = 1'b0;
    chk("R9", int'(busy_o), 0, "busy after last slot");
    chk("R9", int'(done_o), 1, "done after last slot");
    chk("R1", int'(kind_o), 0, "kind when free");
    @(negedge clk_i);
    chk("R9", int'(done_o), 0, "done one cycle");
    chk("R10", int'(busy_o), 0, "no relaunch");
  endtask

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; line_mode_i = 1'b0;
    en_a_i = 1'b0; en_c_i = 1'b0; en_d_i = 1'b0; count_i = '0; grant_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1", int'(busy_o), 0, "reset busy");
    chk("R1", int'(done_o), 0, "reset done");
    chk("R1", int'(kind_o), 0, "reset kind");
    chk("R1", int'(ptr_o), 0, "reset ptr");
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 6; c++)
        for (int e = 0; e < 8; e++)
          for (int gp = 0; gp < 3; gp++)
            run(m[0], c, e[2], e[1], e[0], gp, 1'b0);
    run(1'b0, 4, 1'b1, 1'b1, 1'b1, 0, 1'b1);
    run(1'b1, 3, 1'b1, 1'b1, 1'b0, 1, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule